// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

This block is a 24-stage binary timer that divides an incoming timer clock by a power of two. The timer clock is not used as a clock. It is sampled in the single system clock domain, and each detected rising edge advances the stage counter by one. The output follows one of the upper 16 stages, picked by a 4-bit tap code, so the division ratio runs from 2^9 to 2^24 in the normal chain. A skip control lets the timer edges feed stage 9 directly, which lowers every ratio by 2^8.

Synchronous clear and fill inputs force the counter to all zeros or all ones, and a hold input freezes it. The output can be a level, or a one-cycle pulse on each rise of the tapped stage. A fast-test mode cuts the chain into three independent 8-bit sections that all count together, so every stage can be toggled within 256 timer edges.

Top module: `prog_tap_timer`

## Requirements
- R1: In the normal chain (fast_test=0, skip_low=0), each counted timer edge adds one to the 24-bit stage value, and all ones wraps to zero.
- R2: tap_sel=k makes stage 9+k the tapped stage, which is count bit 8+k. Code 0 gives stage 9 (bit 8) and code 15 gives stage 24 (bit 23). In level mode tmr_out equals that bit.
- R3: With skip_low=1 and fast_test=0, stages 1 to 8 (bits 7:0) keep their value, and each counted edge adds one to the 16-bit value in bits 23:8.
- R4: cnt_clr=1 clears all 24 stages on the next system clock edge. cnt_fill=1 with cnt_clr=0 sets all stages to one. Both override hold and counting, and clear wins over fill.
- R5: While hold=1, timer edges do not change the stage value.
- R6: With pulse_mode=1, tmr_out is high for exactly one system clock after each 0-to-1 transition of the tapped bit, and low otherwise.
- R7: With fast_test=1, each of the sections bits 7:0, 15:8 and 23:16 adds one per counted edge and wraps by itself with no carry between sections. skip_low has no effect in this mode.
- R8: A rise of tmr_clk first sampled at system edge k is counted at edge k+2, and it appears on tmr_out at edge k+3.
- R9: rst=1 clears the stage value, the sampling pipeline and tmr_out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| tmr_clk | input | 1 | Timer clock, sampled as data |
| cnt_clr | input | 1 | Forces all stages to zero |
| cnt_fill | input | 1 | Forces all stages to one |
| hold | input | 1 | Freezes counting |
| skip_low | input | 1 | Routes timer edges straight to stage 9 |
| fast_test | input | 1 | Splits the chain into three parallel 8-bit sections |
| pulse_mode | input | 1 | 1: one-cycle pulse output, 0: level output |
| tap_sel | input | 4 | Selects the tapped stage (9 + code) |
| tmr_out | output | 1 | Registered timer output |

## Verification
A wrong stage value stays hidden until the tapped bit shows it. In the normal chain that can take up to 2^23 timer edges, so the bench pairs low taps with skip mode and fast-test mode, where bit 8 toggles on every edge. In those modes a missed or extra count shows on tmr_out within three system clocks of the edge. Carry and wrap faults in the high stages show only when the bench forces the counter to all ones and then counts one edge. The bench checks tmr_out against its model on every cycle, so a one-cycle slip in the sampling pipeline shows as a mismatch right away.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  typedef enum logic [1:0] {
    CNT_CHAIN = 2'd0,
    CNT_SKIP  = 2'd1,
    CNT_SPLIT = 2'd2
  } cnt_mode_e;
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic tick
);
  logic [SYNC_N-1:0] shr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shr  <= '0;
      prev <= 1'b0;
    end else begin
      shr  <= {shr[SYNC_N-2:0], din};
      prev <= shr[SYNC_N-1];
    end
  end

  assign tick = shr[SYNC_N-1] & ~prev;
endmodule

// File: rtl/stage_chain.sv
module stage_chain
  import tap_timer_pkg::*;
#(
  parameter int STAGES   = 24,
  parameter int SEC_W    = 8,
  parameter int BYP_SECS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fill,
  input  logic              step,
  input  cnt_mode_e         mode,
  output logic [STAGES-1:0] count
);
  localparam int NSEC = STAGES / SEC_W;

  logic [NSEC-1:0] cin;
  logic [NSEC-1:0] cout;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    logic [SEC_W-1:0] sec_q;

    if (i == 0) begin : g_first
      always_comb begin
        case (mode)
          CNT_SPLIT: cin[i] = step;
          CNT_CHAIN: cin[i] = step;
          CNT_SKIP:  cin[i] = (BYP_SECS == 0) ? step : 1'b0;
          default:   cin[i] = 1'b0;
        endcase
      end
    end else begin : g_rest
      always_comb begin
        case (mode)
          CNT_SPLIT: cin[i] = step;
          CNT_CHAIN: cin[i] = cout[i-1];
          CNT_SKIP:  cin[i] = (i == BYP_SECS) ? step : cout[i-1];
          default:   cin[i] = 1'b0;
        endcase
      end
    end

    assign cout[i] = cin[i] & (&sec_q);

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        sec_q <= '0;
      end else if (fill) begin
        sec_q <= '1;
      end else if (cin[i]) begin
        sec_q <= sec_q + 1'b1;
      end
    end

    assign count[i*SEC_W +: SEC_W] = sec_q;
  end
endmodule

// File: rtl/tap_out.sv
module tap_out #(
  parameter int STAGES = 24,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] count,
  input  logic [SEL_W-1:0]  sel,
  input  logic              pulse_mode,
  output logic              out_q
);
  localparam int TAP_N    = 2 ** SEL_W;
  localparam int TAP_BASE = STAGES - TAP_N;

  logic [TAP_N-1:0] taps;
  logic             sel_bit;
  logic             bit_q;

  assign taps    = count[STAGES-1:TAP_BASE];
  assign sel_bit = taps[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      bit_q <= sel_bit;
      out_q <= pulse_mode ? (sel_bit & ~bit_q) : sel_bit;
    end
  end
endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer
  import tap_timer_pkg::*;
#(
  parameter int STAGES   = 24,
  parameter int SEL_W    = 4,
  parameter int SEC_W    = 8,
  parameter int BYP_SECS = 1,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_clk,
  input  logic             cnt_clr,
  input  logic             cnt_fill,
  input  logic             hold,
  input  logic             skip_low,
  input  logic             fast_test,
  input  logic             pulse_mode,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tmr_out
);
  logic              tick;
  logic              step;
  cnt_mode_e         mode;
  logic [STAGES-1:0] cnt_q;

  tick_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (tmr_clk),
    .tick(tick)
  );

  assign step = tick & ~hold;

  always_comb begin
    if (fast_test)     mode = CNT_SPLIT;
    else if (skip_low) mode = CNT_SKIP;
    else               mode = CNT_CHAIN;
  end

  stage_chain #(
    .STAGES  (STAGES),
    .SEC_W   (SEC_W),
    .BYP_SECS(BYP_SECS)
  ) u_chain (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .fill (cnt_fill),
    .step (step),
    .mode (mode),
    .count(cnt_q)
  );

  tap_out #(
    .STAGES(STAGES),
    .SEL_W (SEL_W)
  ) u_tap (
    .clk       (clk),
    .rst       (rst),
    .count     (cnt_q),
    .sel       (tap_sel),
    .pulse_mode(pulse_mode),
    .out_q     (tmr_out)
  );
endmodule

// File: rtl/prog_tap_timer_chk.sv
module prog_tap_timer_chk #(
  parameter int STAGES = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_clr,
  input logic              cnt_fill,
  input logic              hold,
  input logic              pulse_mode,
  input logic              tick,
  input logic [STAGES-1:0] cnt_q,
  input logic              tmr_out
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt_q == '0)); // R4

  AST_FILL_ONES: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && cnt_fill) |=> (&cnt_q)); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !cnt_fill && hold) |=> $stable(cnt_q)); // R5

  AST_NO_EDGE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !cnt_fill && !tick) |=> $stable(cnt_q)); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (tmr_out && pulse_mode && $past(pulse_mode)) |=> !tmr_out); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (cnt_q == '0 && !tmr_out)); // R9
endmodule

bind prog_tap_timer prog_tap_timer_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_clr   (cnt_clr),
  .cnt_fill  (cnt_fill),
  .hold      (hold),
  .pulse_mode(pulse_mode),
  .tick      (tick),
  .cnt_q     (cnt_q),
  .tmr_out   (tmr_out)
);

// File: tb/sim_prog_tap_timer.sv
`timescale 1ns/1ps
module sim_prog_tap_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmr_clk = 1'b0;
  logic       cnt_clr = 1'b0;
  logic       cnt_fill = 1'b0;
  logic       hold = 1'b0;
  logic       skip_low = 1'b0;
  logic       fast_test = 1'b0;
  logic       pulse_mode = 1'b0;
  logic [3:0] tap_sel = 4'd0;
  logic       tmr_out;

  always #2.5 clk = ~clk;

  prog_tap_timer u0 (
    .clk(clk), .rst(rst), .tmr_clk(tmr_clk), .cnt_clr(cnt_clr),
    .cnt_fill(cnt_fill), .hold(hold), .skip_low(skip_low),
    .fast_test(fast_test), .pulse_mode(pulse_mode), .tap_sel(tap_sel),
    .tmr_out(tmr_out)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  bit    toggle = 0;
  string tag = "R9";

  // reference model state
  bit      m_s0, m_s1, m_prev, m_bitprev, m_out;
  longint  m_cnt;
  int      sel_prev_use;

  task automatic model_step();
    bit     tk, b;
    longint c, s0, s1, s2;
    tk = m_s1 && !m_prev;
    b  = ((m_cnt >> (8 + int'(tap_sel))) & 1) != 0;
    c  = m_cnt;
    if (rst) begin
      m_s0 = 0; m_s1 = 0; m_prev = 0; m_cnt = 0; m_bitprev = 0; m_out = 0;
    end else begin
      if (cnt_clr) c = 0;
      else if (cnt_fill) c = 24'hFFFFFF;
      else if (tk && !hold) begin
        if (fast_test) begin
          s0 = ((c & 255) + 1) % 256;
          s1 = (((c >> 8) & 255) + 1) % 256;
          s2 = (((c >> 16) & 255) + 1) % 256;
          c = s0 + s1 * 256 + s2 * 65536;
        end else if (skip_low) c = (c + 256) % 16777216;
        else c = (c + 1) % 16777216;
      end
      m_out     = pulse_mode ? (b && !m_bitprev) : b;
      m_bitprev = b;
      m_prev    = m_s1;
      m_s1      = m_s0;
      m_s0      = tmr_clk;
      m_cnt     = c;
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (toggle) tmr_clk = ~tmr_clk;
      @(posedge clk);
      model_step();
      #1;
      checks++;
      if (tmr_out !== m_out) begin
        errors++;
        $display("FAIL %s: tmr_out=%0b expected %0b at %0t", tag, tmr_out, m_out, $time);
      end
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    tag = "R9"; cyc(4);
    rst = 1'b0;
    cyc(2);

    // R1/R2/R8: normal chain, stage 9 toggles after 256 edges
    tag = "R1"; toggle = 1; tap_sel = 4'd0; cyc(1400);
    tag = "R2"; tap_sel = 4'd1; cyc(300);
    // R1 wrap: fill then count at the top tap
    tag = "R1"; toggle = 0; cnt_fill = 1; cyc(2); cnt_fill = 0;
    tap_sel = 4'd15; cyc(3);
    tag = "R8"; toggle = 1; cyc(12);

    // R3: skip mode, stage 9 toggles per edge
    tag = "R3"; toggle = 0; cnt_clr = 1; cyc(2); cnt_clr = 0;
    skip_low = 1; tap_sel = 4'd0; toggle = 1; cyc(40);
    tap_sel = 4'd3; cyc(60);

    // R7: split test mode, skip has no effect
    tag = "R7"; toggle = 0; cnt_clr = 1; cyc(2); cnt_clr = 0;
    fast_test = 1; tap_sel = 4'd0; toggle = 1; cyc(40);
    tap_sel = 4'd7; cyc(600);
    tap_sel = 4'd8; cyc(40);
    skip_low = 0; tap_sel = 4'd15; cyc(300);

    // R5: hold freezes counting
    tag = "R5"; tap_sel = 4'd0; hold = 1; cyc(30);
    hold = 0; cyc(10);

    // R4: clear beats fill, fill beats hold
    tag = "R4"; hold = 1; cnt_fill = 1; cnt_clr = 1; cyc(3);
    cnt_clr = 0; cyc(3);
    cnt_fill = 0; hold = 0; cyc(10);

    // R6: pulse output on tapped rises
    tag = "R6"; pulse_mode = 1; tap_sel = 4'd0; cyc(60);
    tap_sel = 4'd2; cyc(100);
    pulse_mode = 0; tag = "R2"; cyc(10);

    // R9: reset mid-run
    tag = "R9"; rst = 1; cyc(3); rst = 0; cyc(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule